// File: doc/BRIEF.md
# Serial Wire Debug Target Port

This block is the target-side responder of a two-wire serial debug link. It runs on a system clock and oversamples the host's serial clock and bidirectional data line. It reacts once per rising edge of the serial clock: it takes in request headers and checks them, answers with a three-bit acknowledge, returns read data with parity, and takes in write data and checks its parity. The line is driven only through an output value and an output enable, so the surrounding pad logic forms the open line with its pull-up.

Behind the protocol engine sits a small stand-in register space with two banks of four words. One bank stands for the debug port and one for the access port. Debug-port word 0 reads as a fixed identification code. The other seven words are plain storage. A sticky error flag records a bad write parity. A stall input lets the surroundings refuse access-port traffic with a WAIT answer. A run of more than a set number of consecutive 1 bits on the line returns the protocol to its initial state.

Top module: `swd_target_port`

## Requirements
- R1: A header is taken only when a 1 is sampled while waiting. The header carries, in line order: start (1), bank select (0 debug port, 1 access port), direction (1 read), A2, A3, parity, stop and park. Parity is even over the four bits from bank select to A3. Stop must be 0 and park must be 1. A header that breaks any of these gets no answer: the enable stays low and the port waits for the next start bit.
- R2: After a valid header the line stays released for one turnaround bit. The acknowledge starts in the bit after it.
- R3: The acknowledge goes out as three bits, first bit first: OK is 1,0,0, WAIT is 0,1,0 and FAULT is 0,0,1. The bench holds them as codes with the first bit as LSB: OK=3'b001, WAIT=3'b010, FAULT=3'b100.
- R4: A read answered OK returns 32 data bits, least significant first, then an even parity bit over them. The line is then released for one turnaround bit.
- R5: A write answered OK has one turnaround bit after the acknowledge. Then 32 data bits (LSB first) and an even parity bit are sampled from the host, with no turnaround after them.
- R6: A debug-port read at address 0 returns 0x1BA01477.
- R7: Debug-port addresses 1 to 3 and access-port addresses 0 to 3 keep the last value written. They read 0 after reset.
- R8: A write whose parity bit is wrong discards the data and sets the sticky error flag.
- R9: While the flag is set, every access except a debug-port access at address 0 is answered FAULT and has no data phase. A debug-port write to address 0 that is committed clears the flag. Its data is otherwise ignored.
- R10: While the stall input is high and the flag is clear, access-port requests are answered WAIT, have no data phase and change nothing. Debug-port requests are not affected.
- R11: A run of 51 consecutive sampled 1 bits returns the port to waiting, releases the line and clears the flag. A run of 50 does not clear the flag.
- R12: After reset the line is released and the flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swclk_i | input | 1 | Serial clock from the host |
| swdio_i | input | 1 | Sampled level of the data line |
| ap_stall_i | input | 1 | Access-port not ready; such requests get WAIT |
| swdio_o | output | 1 | Value driven onto the data line |
| swdio_oe_o | output | 1 | Drive enable for the data line |
| err_sticky_o | output | 1 | Sticky write-parity error flag |

## Verification
A wrong protocol state shows within one serial bit. The enable rises in a turnaround bit or a header that should be ignored, or the acknowledge pattern is shifted. Either way the host model sees it in the next bit it samples. A wrong register or flag state shows in the next transaction, as corrupted read data, a parity mismatch, or a FAULT or OK answer where the other was due. The bench sweeps every header and every stand-in word to reach all of these.

// File: rtl/swd_tp_pkg.sv
package swd_tp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_TRN_REQ,
      ST_ACK,
      ST_RDATA,
      ST_TRN_END,
      ST_TRN_WR,
      ST_WDATA
   } swd_state_e;

   // acknowledge codes, bit 0 is the first bit on the line
   localparam logic [2:0] ACK_OK    = 3'b001;
   localparam logic [2:0] ACK_WAIT  = 3'b010;
   localparam logic [2:0] ACK_FAULT = 3'b100;

   typedef struct packed {
      logic       ap;
      logic       rd;
      logic [1:0] addr;
   } swd_req_t;

endpackage

// File: rtl/swd_tp_sync.sv
module swd_tp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic swclk_i,
   input  logic swdio_i,
   output logic rise_o,
   output logic sdi_o
);
   logic [STAGES-1:0] clk_sh;
   logic [STAGES-1:0] dat_sh;
   logic              clk_last;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_sh[0] <= 1'b0;
               dat_sh[0] <= 1'b0;
            end else begin
               clk_sh[0] <= swclk_i;
               dat_sh[0] <= swdio_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_sh[g] <= 1'b0;
               dat_sh[g] <= 1'b0;
            end else begin
               clk_sh[g] <= clk_sh[g-1];
               dat_sh[g] <= dat_sh[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_last <= 1'b0;
      else        clk_last <= clk_sh[STAGES-1];
   end

   assign rise_o = clk_sh[STAGES-1] & ~clk_last;
   assign sdi_o  = dat_sh[STAGES-1];
endmodule

// File: rtl/swd_tp_linerst.sv
module swd_tp_linerst #(
   parameter int ONES = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_evt_i,
   input  logic bit_val_i,
   output logic line_rst_o
);
   localparam int CW = $clog2(ONES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(ONES);

   logic [CW-1:0] run_q;

   // fires on the sampled 1 that makes the run one longer than ONES
   assign line_rst_o = bit_evt_i & bit_val_i & (run_q == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (bit_evt_i) begin
         if (!bit_val_i || line_rst_o) run_q <= '0;
         else                          run_q <= run_q + 1'b1;
      end
   end
endmodule

// File: rtl/swd_tp_regbank.sv
module swd_tp_regbank #(
   parameter int          DW      = 32,
   parameter logic [31:0] ID_CODE = 32'h1BA01477
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic          wr_ap_i,
   input  logic [1:0]    wr_addr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          rd_ap_i,
   input  logic [1:0]    rd_addr_i,
   output logic [DW-1:0] rd_data_o
);
   localparam int NREG = 4;

   logic [DW-1:0] ap_view [NREG];
   logic [DW-1:0] dp_view [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_word
      logic [DW-1:0] ap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   ap_q <= '0;
         else if (wr_en_i && wr_ap_i && wr_addr_i == 2'(g)) ap_q <= wr_data_i;
      end
      assign ap_view[g] = ap_q;

      if (g == 0) begin : g_id
         assign dp_view[g] = DW'(ID_CODE);
      end else begin : g_dp
         logic [DW-1:0] dp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                        dp_q <= '0;
            else if (wr_en_i && !wr_ap_i && wr_addr_i == 2'(g)) dp_q <= wr_data_i;
         end
         assign dp_view[g] = dp_q;
      end
   end

   assign rd_data_o = rd_ap_i ? ap_view[rd_addr_i] : dp_view[rd_addr_i];
endmodule

// File: rtl/swd_target_port.sv
module swd_target_port
   import swd_tp_pkg::*;
#(
   parameter int          DATA_W          = 32,
   parameter logic [31:0] ID_CODE         = 32'h1BA01477,
   parameter int          LINE_RESET_ONES = 50,
   parameter int          SYNC_STAGES     = 2,
   parameter bit          STALL_EN        = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic swclk_i,
   input  logic swdio_i,
   input  logic ap_stall_i,
   output logic swdio_o,
   output logic swdio_oe_o,
   output logic err_sticky_o
);
   localparam int CW = $clog2(DATA_W + 2);
   localparam logic [CW-1:0] LAST_D = CW'(DATA_W);
   localparam logic [CW-1:0] LAST_P = CW'(DATA_W + 1);

   if (DATA_W < 8 || DATA_W > 32) begin : g_bad_width
      $error("swd_target_port: DATA_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("swd_target_port: SYNC_STAGES must be at least 2");
   end
   if (LINE_RESET_ONES < 40) begin : g_bad_run
      $error("swd_target_port: LINE_RESET_ONES must exceed the longest legal run");
   end

   logic bit_evt, sdi, line_rst;

   swd_tp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .swclk_i(swclk_i),
      .swdio_i(swdio_i),
      .rise_o (bit_evt),
      .sdi_o  (sdi)
   );

   swd_tp_linerst #(.ONES(LINE_RESET_ONES)) u_lrst (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_evt_i (bit_evt),
      .bit_val_i (sdi),
      .line_rst_o(line_rst)
   );

   swd_state_e        state_q;
   logic [CW-1:0]     cnt_q;
   logic [6:0]        hdr_q;
   swd_req_t          req_q;
   logic [2:0]        ack_q;
   logic [DATA_W-1:0] sh_q;
   logic              par_q;
   logic              oe_q, out_q, sticky_q;

   // header decode at the park bit
   swd_req_t  hdr_req;
   logic      hdr_ok, stall_hit;
   logic [2:0] ack_next;

   assign hdr_req.ap   = hdr_q[1];
   assign hdr_req.rd   = hdr_q[2];
   assign hdr_req.addr = {hdr_q[4], hdr_q[3]};
   assign hdr_ok = hdr_q[0] & ((^hdr_q[4:1]) == hdr_q[5]) & ~hdr_q[6] & sdi;

   if (STALL_EN) begin : g_stall
      assign stall_hit = hdr_req.ap & ap_stall_i;
   end else begin : g_nostall
      logic unused_stall;
      assign unused_stall = ap_stall_i;
      assign stall_hit    = 1'b0;
   end

   always_comb begin
      if (sticky_q && (hdr_req.ap || hdr_req.addr != 2'd0)) ack_next = ACK_FAULT;
      else if (stall_hit)                                    ack_next = ACK_WAIT;
      else                                                   ack_next = ACK_OK;
   end

   // write data completion
   logic at_wpar, wpar_good, wr_fire, wpar_bad;
   assign at_wpar   = bit_evt & ~line_rst & (state_q == ST_WDATA) & (cnt_q == LAST_D);
   assign wpar_good = ((^sh_q) == sdi);
   assign wr_fire   = at_wpar & wpar_good;
   assign wpar_bad  = at_wpar & ~wpar_good;

   logic [DATA_W-1:0] rd_data;

   swd_tp_regbank #(.DW(DATA_W), .ID_CODE(ID_CODE)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (wr_fire),
      .wr_ap_i  (req_q.ap),
      .wr_addr_i(req_q.addr),
      .wr_data_i(sh_q),
      .rd_ap_i  (req_q.ap),
      .rd_addr_i(req_q.addr),
      .rd_data_o(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= 1'b0;
      end else if (line_rst) begin
         sticky_q <= 1'b0;
      end else if (wpar_bad) begin
         sticky_q <= 1'b1;
      end else if (wr_fire && !req_q.ap && req_q.addr == 2'd0) begin
         sticky_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         hdr_q   <= '0;
         req_q   <= '0;
         ack_q   <= ACK_OK;
         sh_q    <= '0;
         par_q   <= 1'b0;
         oe_q    <= 1'b0;
         out_q   <= 1'b0;
      end else if (line_rst) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         oe_q    <= 1'b0;
         out_q   <= 1'b0;
      end else if (bit_evt) begin
         unique case (state_q)
            ST_IDLE: begin
               if (sdi) begin
                  hdr_q   <= 7'b000_0001;
                  cnt_q   <= CW'(1);
                  state_q <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (cnt_q == CW'(7)) begin
                  if (hdr_ok) begin
                     req_q   <= hdr_req;
                     ack_q   <= ack_next;
                     state_q <= ST_TRN_REQ;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end else begin
                  hdr_q[cnt_q[2:0]] <= sdi;
                  cnt_q             <= cnt_q + 1'b1;
               end
            end
            ST_TRN_REQ: begin
               oe_q    <= 1'b1;
               out_q   <= ack_q[0];
               cnt_q   <= CW'(1);
               state_q <= ST_ACK;
            end
            ST_ACK: begin
               if (cnt_q != CW'(3)) begin
                  out_q <= ack_q[cnt_q[1:0]];
                  cnt_q <= cnt_q + 1'b1;
               end else if (ack_q == ACK_OK && req_q.rd) begin
                  out_q   <= rd_data[0];
                  sh_q    <= rd_data >> 1;
                  par_q   <= ^rd_data;
                  cnt_q   <= CW'(1);
                  state_q <= ST_RDATA;
               end else begin
                  oe_q    <= 1'b0;
                  out_q   <= 1'b0;
                  state_q <= (ack_q == ACK_OK) ? ST_TRN_WR : ST_TRN_END;
               end
            end
            ST_RDATA: begin
               if (cnt_q < LAST_D) begin
                  out_q <= sh_q[0];
                  sh_q  <= sh_q >> 1;
                  cnt_q <= cnt_q + 1'b1;
               end else if (cnt_q == LAST_D) begin
                  out_q <= par_q;
                  cnt_q <= LAST_P;
               end else begin
                  oe_q    <= 1'b0;
                  out_q   <= 1'b0;
                  state_q <= ST_TRN_END;
               end
            end
            ST_TRN_END: begin
               state_q <= ST_IDLE;
            end
            ST_TRN_WR: begin
               cnt_q   <= '0;
               state_q <= ST_WDATA;
            end
            ST_WDATA: begin
               if (cnt_q < LAST_D) begin
                  sh_q  <= {sdi, sh_q[DATA_W-1:1]};
                  cnt_q <= cnt_q + 1'b1;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign swdio_o      = out_q;
   assign swdio_oe_o   = oe_q;
   assign err_sticky_o = sticky_q;
endmodule

// File: rtl/swd_target_port_chk.sv
module swd_target_port_chk
   import swd_tp_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input swd_state_e state_q,
   input logic [2:0] ack_q,
   input swd_req_t   req_q,
   input logic       swdio_oe_o,
   input logic       err_sticky_o,
   input logic       line_rst,
   input logic       wpar_bad
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !swdio_oe_o);

   assert_trn_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TRN_REQ) |-> !swdio_oe_o);

   assert_ack_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACK) |-> ($countones(ack_q) == 1));

   assert_data_after_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RDATA || state_q == ST_WDATA) |-> (ack_q == ACK_OK));

   assert_sticky_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_sticky_o) |-> $past(wpar_bad));

   assert_fault_when_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TRN_REQ && err_sticky_o && req_q.ap) |-> (ack_q == ACK_FAULT));

   assert_line_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      line_rst |=> (!err_sticky_o && !swdio_oe_o && state_q == ST_IDLE));
endmodule

bind swd_target_port swd_target_port_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .state_q     (state_q),
   .ack_q       (ack_q),
   .req_q       (req_q),
   .swdio_oe_o  (swdio_oe_o),
   .err_sticky_o(err_sticky_o),
   .line_rst    (line_rst),
   .wpar_bad    (wpar_bad)
);

// File: tb/swd_target_port_tb_top.sv
module swd_target_port_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 4;
   localparam int WD_LIMIT   = 180000;
   localparam logic [2:0] K_OK    = 3'b001;
   localparam logic [2:0] K_WAIT  = 3'b010;
   localparam logic [2:0] K_FAULT = 3'b100;
   localparam logic [31:0] K_ID   = 32'h1BA01477;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic swclk = 1'b0;
   logic host_oe = 1'b1;
   logic host_v = 1'b0;
   logic ap_stall = 1'b0;
   logic t_out, t_oe, t_err;
   logic line;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign line = t_oe ? t_out : (host_oe ? host_v : 1'b1);

   swd_target_port dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .swclk_i     (swclk),
      .swdio_i     (line),
      .ap_stall_i  (ap_stall),
      .swdio_o     (t_out),
      .swdio_oe_o  (t_oe),
      .err_sticky_o(t_err)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one serial bit: host drives (or releases), samples line and enable before the rise
   task automatic slot(input logic drv, input logic val, output logic smp, output logic oe_s);
      swclk   = 1'b0;
      host_oe = drv;
      host_v  = val;
      repeat (HALF) @(negedge clk);
      smp  = line;
      oe_s = t_oe;
      swclk = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic idle(input int n);
      logic s, o;
      for (int i = 0; i < n; i++) slot(1'b1, 1'b0, s, o);
   endtask

   // bad: 0 none, 1 header parity, 2 stop high, 3 park low
   task automatic txn(input logic ap, input logic rd, input logic [1:0] a,
                      input logic [31:0] wdata, input int bad, input logic wflip,
                      output logic [2:0] ack, output logic [31:0] rdata,
                      output logic rpar, output bit quiet);
      logic s, o, hp;
      quiet = 1'b1;
      ack   = 3'b000;
      rdata = '0;
      rpar  = 1'b0;
      idle(2);
      hp = ap ^ rd ^ a[0] ^ a[1];
      if (bad == 1) hp = ~hp;
      slot(1'b1, 1'b1, s, o);
      slot(1'b1, ap, s, o);
      slot(1'b1, rd, s, o);
      slot(1'b1, a[0], s, o);
      slot(1'b1, a[1], s, o);
      slot(1'b1, hp, s, o);
      slot(1'b1, (bad == 2), s, o);
      if (bad == 3) slot(1'b1, 1'b0, s, o);
      else          slot(1'b0, 1'b0, s, o);
      if (bad != 0) begin
         for (int i = 0; i < 40; i++) begin
            slot(1'b1, 1'b0, s, o);
            if (o) quiet = 1'b0;
         end
         return;
      end
      slot(1'b0, 1'b0, s, o);
      if (o) quiet = 1'b0;
      for (int i = 0; i < 3; i++) begin
         slot(1'b0, 1'b0, s, o);
         ack[i] = s;
      end
      if (ack == K_OK && rd) begin
         for (int i = 0; i < 32; i++) begin
            slot(1'b0, 1'b0, s, o);
            rdata[i] = s;
         end
         slot(1'b0, 1'b0, s, o);
         rpar = s;
         slot(1'b0, 1'b0, s, o);
         if (o) quiet = 1'b0;
      end else begin
         slot(1'b0, 1'b0, s, o);
         if (o) quiet = 1'b0;
         if (ack == K_OK) begin
            for (int i = 0; i < 32; i++) slot(1'b1, wdata[i], s, o);
            slot(1'b1, (^wdata) ^ wflip, s, o);
         end
      end
      idle(2);
   endtask

   task automatic do_read(input logic ap, input logic [1:0] a, input logic [2:0] exp_ack,
                          input logic [31:0] exp_d, input string req);
      logic [2:0] ack; logic [31:0] d; logic p; bit q;
      txn(ap, 1'b1, a, '0, 0, 1'b0, ack, d, p, q);
      check(ack == exp_ack, {req, " R3 ack"}, {29'd0, ack}, {29'd0, exp_ack});
      check(q, {req, " R2 turnaround released"}, {31'd0, q}, 32'd1);
      if (exp_ack == K_OK) begin
         check(d == exp_d, {req, " data"}, d, exp_d);
         check(p == ^exp_d, {req, " R4 parity"}, {31'd0, p}, {31'd0, ^exp_d});
      end
   endtask

   task automatic do_write(input logic ap, input logic [1:0] a, input logic [31:0] v,
                           input logic wflip, input logic [2:0] exp_ack, input string req);
      logic [2:0] ack; logic [31:0] d; logic p; bit q;
      txn(ap, 1'b0, a, v, 0, wflip, ack, d, p, q);
      check(ack == exp_ack, {req, " R5 write ack"}, {29'd0, ack}, {29'd0, exp_ack});
      check(q, {req, " R2 turnaround released"}, {31'd0, q}, 32'd1);
   endtask

   task automatic ones(input int n);
      logic s, o;
      for (int i = 0; i < n; i++) slot(1'b1, 1'b1, s, o);
      idle(8);
   endtask

   function automatic logic [31:0] pat(input int ap, input int a, input int k);
      return (32'h9E3779B1 * (ap * 16 + a * 4 + k + 1)) ^ (32'h1 << (a * 8 + ap * 4 + k));
   endfunction

   initial begin : main
      logic [2:0] ack; logic [31:0] d; logic p; bit q;
      repeat (5) @(negedge clk);
      check(!t_oe, "R12 released in reset", {31'd0, t_oe}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!t_oe, "R12 released after reset", {31'd0, t_oe}, 32'd0);
      check(!t_err, "R12 flag clear after reset", {31'd0, t_err}, 32'd0);
      idle(4);

      do_read(1'b0, 2'd0, K_OK, K_ID, "R6 id read");

      // R7 reset values of every stand-in word
      for (int ap = 0; ap < 2; ap++)
         for (int a = 0; a < 4; a++)
            if (ap == 1 || a != 0) do_read(ap[0], a[1:0], K_OK, 32'd0, "R7 reset value");

      // R7 R4 R5 sweep: write, read back
      for (int k = 0; k < 3; k++)
         for (int ap = 0; ap < 2; ap++)
            for (int a = 0; a < 4; a++)
               if (ap == 1 || a != 0) begin
                  do_write(ap[0], a[1:0], pat(ap, a, k), 1'b0, K_OK, "R5 sweep");
                  do_read(ap[0], a[1:0], K_OK, pat(ap, a, k), "R7 readback");
               end
      // all words kept independently
      for (int ap = 0; ap < 2; ap++)
         for (int a = 0; a < 4; a++)
            if (ap == 1 || a != 0) do_read(ap[0], a[1:0], K_OK, pat(ap, a, 2), "R7 isolation");

      do_write(1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0, K_OK, "R5 all ones");
      do_read(1'b1, 2'd3, K_OK, 32'hFFFF_FFFF, "R4 all ones");
      do_write(1'b1, 2'd3, 32'h8000_0001, 1'b0, K_OK, "R5 edge bits");
      do_read(1'b1, 2'd3, K_OK, 32'h8000_0001, "R4 lsb first");
      do_write(1'b0, 2'd0, 32'hFFFF_FFFF, 1'b0, K_OK, "R9 id write ignored");
      do_read(1'b0, 2'd0, K_OK, K_ID, "R6 id unchanged");

      // R1 every header with each kind of fault
      for (int h = 0; h < 16; h++)
         for (int b = 1; b < 4; b++) begin
            txn(h[0], h[1], h[3:2], 32'h0, b, 1'b0, ack, d, p, q);
            check(q, "R1 malformed header not answered", {31'd0, q}, 32'd1);
         end
      do_read(1'b0, 2'd0, K_OK, K_ID, "R1 recovers after bad headers");
      do_read(1'b1, 2'd3, K_OK, 32'h8000_0001, "R1 bad headers wrote nothing");

      // R10 stall
      ap_stall = 1'b1;
      do_read(1'b1, 2'd1, K_WAIT, 32'd0, "R10 stalled read");
      do_write(1'b1, 2'd1, 32'hDEAD_BEEF, 1'b0, K_WAIT, "R10 stalled write");
      do_read(1'b0, 2'd1, K_OK, pat(0, 1, 2), "R10 dp unaffected");
      ap_stall = 1'b0;
      do_read(1'b1, 2'd1, K_OK, pat(1, 1, 2), "R10 stalled write discarded");

      // R8 R9 sticky flag
      do_write(1'b0, 2'd2, 32'h1234_5678, 1'b1, K_OK, "R8 bad parity write");
      check(t_err, "R8 flag set", {31'd0, t_err}, 32'd1);
      do_read(1'b0, 2'd2, K_FAULT, 32'd0, "R9 dp read faults");
      do_read(1'b1, 2'd0, K_FAULT, 32'd0, "R9 ap read faults");
      do_write(1'b1, 2'd0, 32'h5555_5555, 1'b0, K_FAULT, "R9 ap write faults");
      ap_stall = 1'b1;
      do_read(1'b1, 2'd0, K_FAULT, 32'd0, "R9 fault before wait");
      ap_stall = 1'b0;
      do_read(1'b0, 2'd0, K_OK, K_ID, "R9 id read allowed");
      do_write(1'b0, 2'd0, 32'h0, 1'b0, K_OK, "R9 clearing write");
      check(!t_err, "R9 flag cleared", {31'd0, t_err}, 32'd0);
      do_read(1'b0, 2'd2, K_OK, pat(0, 2, 2), "R8 bad write discarded");
      do_read(1'b1, 2'd0, K_OK, pat(1, 0, 2), "R9 faulted write discarded");

      // R11 line reset
      do_write(1'b0, 2'd1, 32'h0F0F_0F0F, 1'b1, K_OK, "R11 set flag");
      check(t_err, "R11 flag set before run", {31'd0, t_err}, 32'd1);
      ones(50);
      check(t_err, "R11 run of 50 keeps flag", {31'd0, t_err}, 32'd1);
      check(!t_oe, "R11 run of 50 no drive", {31'd0, t_oe}, 32'd0);
      ones(51);
      check(!t_err, "R11 run of 51 clears flag", {31'd0, t_err}, 32'd0);
      do_read(1'b0, 2'd1, K_OK, pat(0, 1, 2), "R11 port usable after reset");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : watchdog
      repeat (WD_LIMIT) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule